// File: doc/BRIEF.md
# Priority Current-Result Shadow Register

This block stores the latest conversion result of each of thirteen converter sample slots. Every slot keeps a data word, a valid flag and an overrun flag. A conversion engine delivers one finished result per cycle through a single write port. The block sets that slot's valid flag, and it raises the overrun flag when the previous result in the slot was never consumed.

The block also drives one shadow "current result" output. That output always shows the lowest-numbered slot that holds a valid result, together with the slot number, so that a reader can tell where the data came from. A DMA engine pulses a read strobe to take the shown result. On the next clock edge the block clears that slot's valid flag, and the shadow output then moves to the next valid slot. When no slot is valid, the shadow output keeps the last slot number and data it showed, with its valid bit low. A separate indexed port lets a reader look at any slot without changing its flags.

Top module: `result_shadow_bank`

## Requirements
- R1: After reset every slot has its valid and overrun flags at 0 and its data at 0. The shadow output shows valid 0, slot 0 and data 0.
- R2: A write (`cnv_done` high, `cnv_slot` = k, k < 13) stores `cnv_result` in slot k and sets its valid flag at the next clock edge. `peek_slot` = k shows both from then on.
- R3: In the same cycle the valid flags change, `cur_valid`, `cur_slot` and `cur_result` show the lowest-numbered slot whose valid flag is set. Slot 0 has the highest priority.
- R4: `dma_rd` high while `cur_valid` is 1 clears the valid flag of the slot shown in `cur_slot` at the next clock edge. All other slots and the stored data are left unchanged.
- R5: If a write to slot k and a DMA read of slot k happen in the same cycle, the write wins. Slot k stays valid and holds the new data.
- R6: A write to a slot whose valid flag is already set, and which is not consumed by a DMA read in the same cycle, sets that slot's overrun flag. The flag reads on `peek_ovr`.
- R7: A DMA read of a slot clears that slot's overrun flag at the next clock edge. This holds even when a write to the same slot arrives in that cycle.
- R8: While no slot is valid, `cur_valid` is 0 and `cur_slot` / `cur_result` keep the slot number and data that were last shown with `cur_valid` at 1.
- R9: `dma_rd` while no slot is valid changes no slot flag and no shadow output.
- R10: A write with `cnv_slot` of 13 or higher changes no slot.
- R11: `peek_slot` of 13 or higher returns `peek_valid` 0, `peek_ovr` 0 and `peek_result` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised on release |
| cnv_done | input | 1 | Conversion result strobe |
| cnv_slot | input | 4 | Slot that finished converting |
| cnv_result | input | 16 | Conversion result data |
| dma_rd | input | 1 | DMA read strobe on the shadow output |
| cur_valid | output | 1 | Shadow output holds a valid result |
| cur_slot | output | 4 | Slot number shown on the shadow output |
| cur_result | output | 16 | Result data shown on the shadow output |
| peek_slot | input | 4 | Slot selected for the indexed read |
| peek_valid | output | 1 | Valid flag of the indexed slot |
| peek_ovr | output | 1 | Overrun flag of the indexed slot |
| peek_result | output | 16 | Stored data of the indexed slot |

## Verification
The assertions assume that reset is held low for at least one clock edge before any stimulus. They also assume that the slot inputs never carry X while their strobes are high. Beyond that, any mix of writes and DMA strobes is legal. The bench therefore drives every input on the falling edge with defined values from reset onward. Its slot indices span the full 4-bit range, which covers the out-of-range writes and peeks as well. DMA strobes are issued both while the shadow output is valid and while no slot is valid.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int SHADOW_SLOTS_DEF = 13;
  localparam int SHADOW_DATA_DEF  = 16;

  typedef struct packed {
    logic valid;
    logic ovr;
  } slot_flags_t;
endpackage

// File: rtl/result_slot.sv
module result_slot
  import shadow_pkg::*;
#(
  parameter int SLOT_ID = 0,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  output slot_flags_t       flags_o,
  output logic [DATA_W-1:0] data_o
);
  slot_flags_t       flags_q, flags_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_ce;
  logic              wr_hit;

  always_comb begin
    wr_hit  = wr_en && (wr_idx == IDX_W'(SLOT_ID));
    data_ce = wr_hit;
    data_d  = wr_data;
    flags_d = flags_q;
    if (wr_hit) begin
      flags_d.valid = 1'b1;
      if (clr_en)             flags_d.ovr = 1'b0;
      else if (flags_q.valid) flags_d.ovr = 1'b1;
    end else if (clr_en) begin
      flags_d.valid = 1'b0;
      flags_d.ovr   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      data_q  <= '0;
    end else begin
      flags_q <= flags_d;
      if (data_ce) data_q <= data_d;
    end
  end

  assign flags_o = flags_q;
  assign data_o  = data_q;

  // R5
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (flags_q.valid && data_q == $past(wr_data)));
  // R4
  consume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_hit) |=> !flags_q.valid);
  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && flags_q.valid && !clr_en) |=> flags_q.ovr);
  // R7
  overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !flags_q.ovr);
endmodule

// File: rtl/prio_select.sv
module prio_select #(
  parameter int NUM_SLOTS = 13,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_SLOTS-1:0]             valid_vec,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] data_vec,
  output logic [NUM_SLOTS-1:0]             grant,
  output logic [IDX_W-1:0]                 sel_idx,
  output logic [DATA_W-1:0]                sel_data,
  output logic                             any_valid
);
  always_comb begin
    grant     = '0;
    sel_idx   = '0;
    any_valid = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (valid_vec[i] && !any_valid) begin
        any_valid = 1'b1;
        grant[i]  = 1'b1;
        sel_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      sel_data = sel_data | (data_vec[i] & {DATA_W{grant[i]}});
    end
  end
endmodule

// File: rtl/shadow_hold.sv
module shadow_hold #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    idx_d  = cap_en ? idx_in  : idx_q;
    data_d = cap_en ? data_in : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      idx_q  <= idx_d;
      data_q <= data_d;
    end
  end

  assign idx_o  = idx_q;
  assign data_o = data_q;
endmodule

// File: rtl/peek_mux.sv
module peek_mux
  import shadow_pkg::*;
#(
  parameter int NUM_SLOTS = 13,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 4
) (
  input  logic [IDX_W-1:0]                 idx,
  input  slot_flags_t [NUM_SLOTS-1:0]      flags_vec,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] data_vec,
  output logic                             valid_o,
  output logic                             ovr_o,
  output logic [DATA_W-1:0]                data_o
);
  always_comb begin
    valid_o = 1'b0;
    ovr_o   = 1'b0;
    data_o  = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (idx == IDX_W'(i)) begin
        valid_o = flags_vec[i].valid;
        ovr_o   = flags_vec[i].ovr;
        data_o  = data_vec[i];
      end
    end
  end
endmodule

// File: rtl/result_shadow_bank.sv
module result_shadow_bank
  import shadow_pkg::*;
#(
  parameter  int NUM_SLOTS = SHADOW_SLOTS_DEF,
  parameter  int DATA_W    = SHADOW_DATA_DEF,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_done,
  input  logic [IDX_W-1:0]  cnv_slot,
  input  logic [DATA_W-1:0] cnv_result,
  input  logic              dma_rd,
  output logic              cur_valid,
  output logic [IDX_W-1:0]  cur_slot,
  output logic [DATA_W-1:0] cur_result,
  input  logic [IDX_W-1:0]  peek_slot,
  output logic              peek_valid,
  output logic              peek_ovr,
  output logic [DATA_W-1:0] peek_result
);
  slot_flags_t [NUM_SLOTS-1:0]      flags_vec;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] data_vec;
  logic [NUM_SLOTS-1:0]             valid_vec;
  logic [NUM_SLOTS-1:0]             grant;
  logic [NUM_SLOTS-1:0]             clr_vec;
  logic [IDX_W-1:0]                 sel_idx, hold_idx;
  logic [DATA_W-1:0]                sel_data, hold_data;
  logic                             any_valid;
  logic                             consume;

  assign consume = dma_rd && any_valid;
  assign clr_vec = grant & {NUM_SLOTS{consume}};

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    result_slot #(
      .SLOT_ID (g),
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cnv_done),
      .wr_idx  (cnv_slot),
      .wr_data (cnv_result),
      .clr_en  (clr_vec[g]),
      .flags_o (flags_vec[g]),
      .data_o  (data_vec[g])
    );
    assign valid_vec[g] = flags_vec[g].valid;
  end

  prio_select #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
  ) u_prio (
    .valid_vec (valid_vec),
    .data_vec  (data_vec),
    .grant     (grant),
    .sel_idx   (sel_idx),
    .sel_data  (sel_data),
    .any_valid (any_valid)
  );

  shadow_hold #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (any_valid),
    .idx_in  (sel_idx),
    .data_in (sel_data),
    .idx_o   (hold_idx),
    .data_o  (hold_data)
  );

  peek_mux #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
  ) u_peek (
    .idx       (peek_slot),
    .flags_vec (flags_vec),
    .data_vec  (data_vec),
    .valid_o   (peek_valid),
    .ovr_o     (peek_ovr),
    .data_o    (peek_result)
  );

  always_comb begin
    cur_valid  = any_valid;
    cur_slot   = any_valid ? sel_idx  : hold_idx;
    cur_result = any_valid ? sel_data : hold_data;
  end

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant != '0) == (valid_vec != '0)));
  // R3
  prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_vec & (grant - NUM_SLOTS'(1))) == '0) && ((grant & ~valid_vec) == '0));
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_valid && !$past(cur_valid)) |-> ($stable(cur_slot) && $stable(cur_result)));
  // R9
  dma_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd && !cur_valid && !cnv_done) |=> (valid_vec == '0));
  // R10
  bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_done && ({1'b0, cnv_slot} >= (IDX_W+1)'(NUM_SLOTS)) && !dma_rd)
      |=> (flags_vec == $past(flags_vec) && data_vec == $past(data_vec)));
endmodule

// File: tb/sim_result_shadow_bank.sv
`timescale 1ns/1ps
module sim_result_shadow_bank;
  localparam int NS = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnv_done, dma_rd;
  logic [3:0]  cnv_slot, peek_slot;
  logic [15:0] cnv_result;
  logic        cur_valid, peek_valid, peek_ovr;
  logic [3:0]  cur_slot;
  logic [15:0] cur_result, peek_result;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  int m_v[NS];
  int m_o[NS];
  int m_d[NS];
  int h_idx, h_dat;

  always #2 clk = ~clk;

  result_shadow_bank u0 (
    .clk(clk), .rst_n(rst_n), .cnv_done(cnv_done), .cnv_slot(cnv_slot),
    .cnv_result(cnv_result), .dma_rd(dma_rd), .cur_valid(cur_valid),
    .cur_slot(cur_slot), .cur_result(cur_result), .peek_slot(peek_slot),
    .peek_valid(peek_valid), .peek_ovr(peek_ovr), .peek_result(peek_result)
  );

  function automatic int first_valid();
    for (int i = 0; i < NS; i++) if (m_v[i] != 0) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin m_v[i] = 0; m_o[i] = 0; m_d[i] = 0; end
      h_idx = 0; h_dat = 0;
    end else begin
      int s;
      int w;
      s = first_valid();
      w = (cnv_done && cnv_slot < NS) ? int'(cnv_slot) : -1;
      if (s >= 0) begin h_idx = s; h_dat = m_d[s]; end
      if (dma_rd && s >= 0) begin m_v[s] = 0; m_o[s] = 0; end
      if (w >= 0) begin
        if (m_v[w] != 0) m_o[w] = 1;
        if (dma_rd && s == w) m_o[w] = 0;
        m_v[w] = 1;
        m_d[w] = cnv_result;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int s;
    s = first_valid();
    chk("cur_valid", cur_valid, s >= 0);
    chk("cur_slot", cur_slot, s >= 0 ? s : h_idx);
    chk("cur_result", cur_result, s >= 0 ? m_d[s] : h_dat);
    chk("peek_valid", peek_valid, peek_slot < NS ? m_v[peek_slot] : 0);
    chk("peek_ovr", peek_ovr, peek_slot < NS ? m_o[peek_slot] : 0);
    chk("peek_result", peek_result, peek_slot < NS ? m_d[peek_slot] : 0);
  endtask

  task automatic step(string t, bit wr, int slot, int data, bit rd, int pk);
    @(negedge clk);
    tag        = t;
    cnv_done   = wr;
    cnv_slot   = 4'(slot);
    cnv_result = 16'(data);
    dma_rd     = rd;
    peek_slot  = 4'(pk);
    #1 compare_all();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnv_done = 0; cnv_slot = 0; cnv_result = 0; dma_rd = 0; peek_slot = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int k = 0; k < NS; k += 4) begin peek_slot = 4'(k); #1 compare_all(); end
    @(negedge clk) rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0);
    // R2 plain writes
    step("R2", 1, 5, 16'h0505, 0, 5);
    step("R2", 1, 9, 16'h0909, 0, 5);
    step("R3", 1, 2, 16'h0202, 0, 9);
    step("R3", 0, 0, 0, 0, 2);
    // R4 consume slot 2, slot 5 appears
    step("R4", 0, 0, 0, 1, 2);
    step("R4", 0, 0, 0, 0, 2);
    // R6 overwrite slot 5 while valid
    step("R6", 1, 5, 16'h5555, 0, 5);
    step("R6", 0, 0, 0, 0, 5);
    // R7 consume slot 5 clears overrun
    step("R7", 0, 0, 0, 1, 5);
    step("R7", 0, 0, 0, 0, 5);
    // R5 write and consume slot 9 together
    step("R5", 1, 9, 16'h9999, 1, 9);
    step("R5", 0, 0, 0, 0, 9);
    // R8 drain to empty, hold last
    step("R8", 0, 0, 0, 1, 9);
    step("R8", 0, 0, 0, 0, 9);
    step("R8", 0, 0, 0, 0, 3);
    // R9 DMA with nothing valid
    step("R9", 0, 0, 0, 1, 9);
    step("R9", 0, 0, 0, 0, 9);
    // R10 out-of-range writes
    step("R10", 1, 13, 16'hdead, 0, 0);
    step("R10", 1, 15, 16'hbeef, 0, 12);
    step("R10", 0, 0, 0, 0, 0);
    // R11 out-of-range peeks
    step("R11", 1, 12, 16'h0c0c, 0, 13);
    step("R11", 0, 0, 0, 0, 14);
    step("R11", 0, 0, 0, 0, 15);
    // R3 random mix
    for (int n = 0; n < 4000; n++) begin
      step("R3", ($urandom_range(0, 1) == 1), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 65535)), ($urandom_range(0, 2) == 0),
           int'($urandom_range(0, 15)));
    end
    step("R3", 0, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule